// File: doc/BRIEF.md
# L1 Sleep State Tracker

This block follows a USB port into and out of the L1 low-power sleep state in either role. As a device, it arms a residency countdown when it has acknowledged a link power-management request, and it declares sleep once that countdown runs out. As a host, it declares sleep as soon as the attached device acknowledges the request. Each role has its own set of wake events, and each of them ends sleep.

Once sleep begins, a fixed delay of 50 microseconds runs inside the block. When the delay ends, a resume-permitted flag is raised. That flag can only be 1 while the sleep flag is 1. A single prescaler, set by a cycles-per-microsecond parameter, drives both the residency countdown and the resume delay. Software can read the sleep flag to decide whether the PHY clock may be stopped.

Top module: `l1_sleep_tracker`

## Requirements
- R1: After reset, `sleep_o` and `resume_ok_o` are both 0.
- R2: In device role (`host_mode`=0), `lpm_ack` with `residency_us`=R>0 makes `sleep_o` rise exactly R*CYC_PER_US clock edges after the edge that samples `lpm_ack`. When R=0, `sleep_o` rises on the next edge.
- R3: In device role, a one-cycle pulse on `line_activity`, `sw_wakeup`, `dev_reset` or `soft_disc` clears `sleep_o` and `resume_ok_o` on the next edge. The same pulse also cancels a residency countdown that has not yet finished.
- R4: In host role (`host_mode`=1), `lpm_ack` sets `sleep_o` on the next edge.
- R5: In host role, a one-cycle pulse on `remote_wake`, `port_reset`, `port_resume`, `wake_irq` or `disc_irq` clears `sleep_o` on the next edge.
- R6: The wake inputs of the inactive role have no effect on `sleep_o`.
- R7: `resume_ok_o` rises exactly RESUME_US*CYC_PER_US edges after the edge on which `sleep_o` rose, and it stays at 1 until sleep ends.
- R8: `resume_ok_o` is 0 whenever `sleep_o` is 0.
- R9: If a wake event of the active role arrives in the same cycle as an entry event, the wake event wins and `sleep_o` stays 0.
- R10: `lpm_ack` is ignored while the block is asleep, and in particular it does not restart the resume delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| residency_us | input | RES_W | Device residency time in microseconds |
| lpm_ack | input | 1 | Power-management request acknowledged (sent as device, received as host) |
| line_activity | input | 1 | Device: bus line-state activity |
| sw_wakeup | input | 1 | Device: software remote-wakeup write |
| dev_reset | input | 1 | Device: reset |
| soft_disc | input | 1 | Device: soft disconnect |
| remote_wake | input | 1 | Host: remote wakeup detected |
| port_reset | input | 1 | Host: port reset command |
| port_resume | input | 1 | Host: port resume command |
| wake_irq | input | 1 | Host: wakeup interrupt bit set |
| disc_irq | input | 1 | Host: disconnect interrupt bit set |
| sleep_o | output | 1 | Port is in L1 sleep |
| resume_ok_o | output | 1 | Resume from sleep is permitted |

## Verification
The bench measures the exact edge on which the residency countdown and the 50 µs delay finish. A prescaler that is off by one would move either event by a cycle. It pulses every wake input in both roles: wiring a wake input to the wrong role would either leave a real wake event unheard or let a foreign one clear sleep. It drives entry and exit together and expects sleep to stay off, and it cancels a countdown partway through to catch a design that remembers the stale entry. A repeated acknowledge in the middle of the delay must leave the timing unchanged; a design that restarted the delay would raise resume-permitted late.

// File: rtl/l1_sleep_tracker.sv
module l1_sleep_tracker #(
  parameter int CYC_PER_US = 4,
  parameter int RESUME_US  = 50,
  parameter int RES_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_mode,
  input  logic [RES_W-1:0] residency_us,
  input  logic             lpm_ack,
  input  logic             line_activity,
  input  logic             sw_wakeup,
  input  logic             dev_reset,
  input  logic             soft_disc,
  input  logic             remote_wake,
  input  logic             port_reset,
  input  logic             port_resume,
  input  logic             wake_irq,
  input  logic             disc_irq,
  output logic             sleep_o,
  output logic             resume_ok_o
);
  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int DLY_W = $clog2(RESUME_US + 1);
  localparam int US_W  = (RES_W > DLY_W) ? RES_W : DLY_W;

  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  us_left_q;
  logic             pend_q, sleep_q, ok_q;

  wire dev_exit  = !host_mode && (line_activity || sw_wakeup || dev_reset || soft_disc);
  wire host_exit = host_mode && (remote_wake || port_reset || port_resume || wake_irq || disc_irq);
  wire exit_ev   = dev_exit || host_exit;

  wire running   = pend_q || (sleep_q && !ok_q);
  wire us_tick   = running && (pre_q == PRE_W'(CYC_PER_US - 1));
  wire last_us   = (us_left_q == US_W'(1));
  wire ack_ok    = lpm_ack && !sleep_q && !pend_q;
  wire start_res = ack_ok && !host_mode && (residency_us != '0);
  wire enter_now = (ack_ok && (host_mode || residency_us == '0)) ||
                   (pend_q && us_tick && last_us);

  always_ff @(posedge clk) begin
    if (!rst_n || exit_ev) begin
      sleep_q   <= 1'b0;
      pend_q    <= 1'b0;
      ok_q      <= 1'b0;
      pre_q     <= '0;
      us_left_q <= '0;
    end else if (start_res) begin
      pend_q    <= 1'b1;
      pre_q     <= '0;
      us_left_q <= US_W'(residency_us);
    end else if (enter_now) begin
      sleep_q   <= 1'b1;
      pend_q    <= 1'b0;
      pre_q     <= '0;
      us_left_q <= US_W'(RESUME_US);
    end else if (us_tick) begin
      pre_q     <= '0;
      us_left_q <= us_left_q - US_W'(1);
      if (last_us) ok_q <= 1'b1;
    end else if (running) begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  assign sleep_o     = sleep_q;
  assign resume_ok_o = ok_q;

  assert_ok_needs_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_ok_o |-> sleep_o);

  assert_host_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode && lpm_ack &&
    !(remote_wake || port_reset || port_resume || wake_irq || disc_irq) |=> sleep_o);

  assert_host_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode && (remote_wake || port_reset || port_resume || wake_irq || disc_irq)
    |=> !sleep_o);

  assert_dev_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode && (line_activity || sw_wakeup || dev_reset || soft_disc)
    |=> !sleep_o && !resume_ok_o);

  assert_dev_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode && lpm_ack && !sleep_o && !pend_q && residency_us != '0 |=> !sleep_o);

  assert_ok_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_ok_o) |-> $past(sleep_o));
endmodule

// File: tb/l1_sleep_tracker_tb_top.sv
module l1_sleep_tracker_tb_top;
  localparam int CYC = 4;
  localparam int RUS = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_mode = 1'b0;
  logic [7:0] residency_us = '0;
  logic lpm_ack = 1'b0;
  logic [8:0] wk = '0;
  logic sleep_o, resume_ok_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  l1_sleep_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .residency_us(residency_us),
    .lpm_ack(lpm_ack), .line_activity(wk[0]), .sw_wakeup(wk[1]), .dev_reset(wk[2]),
    .soft_disc(wk[3]), .remote_wake(wk[4]), .port_reset(wk[5]), .port_resume(wk[6]),
    .wake_irq(wk[7]), .disc_irq(wk[8]), .sleep_o(sleep_o), .resume_ok_o(resume_ok_o));

  // {host role, wake index (0-3 device, 4-8 host), expect clear}
  localparam logic [5:0] VEC [0:12] = '{
    {1'b0, 4'd0, 1'b1}, {1'b0, 4'd1, 1'b1}, {1'b0, 4'd2, 1'b1}, {1'b0, 4'd3, 1'b1},
    {1'b1, 4'd4, 1'b1}, {1'b1, 4'd5, 1'b1}, {1'b1, 4'd6, 1'b1}, {1'b1, 4'd7, 1'b1},
    {1'b1, 4'd8, 1'b1}, {1'b0, 4'd5, 1'b0}, {1'b0, 4'd8, 1'b0}, {1'b1, 4'd0, 1'b0},
    {1'b1, 4'd3, 1'b0}};

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lpm_ack = 1'b0; wk = '0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic pulse_ack();
    lpm_ack = 1'b1; tick(1); lpm_ack = 1'b0;
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 sleep", sleep_o, 1'b0);
    chk("R1 resume_ok", resume_ok_o, 1'b0);

    for (int i = 0; i < 13; i++) begin
      do_reset();
      host_mode = VEC[i][5];
      residency_us = '0;
      pulse_ack();
      chk(host_mode ? "R4 entry" : "R2 zero residency", sleep_o, 1'b1);
      wk[VEC[i][4:1]] = 1'b1; tick(1); wk = '0;
      if (VEC[i][0])
        chk(host_mode ? "R5 wake clears" : "R3 wake clears", sleep_o, 1'b0);
      else
        chk("R6 foreign wake ignored", sleep_o, 1'b1);
    end

    // R2 exact residency timing, then R7 resume delay
    do_reset();
    host_mode = 1'b0; residency_us = 8'd3;
    pulse_ack();
    tick(3 * CYC - 1);
    chk("R2 before residency end", sleep_o, 1'b0);
    tick(1);
    chk("R2 at residency end", sleep_o, 1'b1);
    tick(RUS * CYC - 1);
    chk("R7 before delay end", resume_ok_o, 1'b0);
    tick(1);
    chk("R7 at delay end", resume_ok_o, 1'b1);
    tick(20);
    chk("R7 holds", resume_ok_o, 1'b1);
    wk[1] = 1'b1; tick(1); wk = '0;
    chk("R3 clears sleep", sleep_o, 1'b0);
    chk("R8 resume_ok follows sleep", resume_ok_o, 1'b0);

    // R3 pending countdown cancelled
    do_reset();
    host_mode = 1'b0; residency_us = 8'd2;
    pulse_ack();
    tick(3);
    wk[0] = 1'b1; tick(1); wk = '0;
    tick(4 * CYC);
    chk("R3 countdown cancelled", sleep_o, 1'b0);

    // R9 exit wins over entry (host)
    do_reset();
    host_mode = 1'b1;
    lpm_ack = 1'b1; wk[5] = 1'b1; tick(1); lpm_ack = 1'b0; wk = '0;
    chk("R9 host exit priority", sleep_o, 1'b0);

    // R9 exit wins over entry (device, zero residency)
    do_reset();
    host_mode = 1'b0; residency_us = '0;
    lpm_ack = 1'b1; wk[3] = 1'b1; tick(1); lpm_ack = 1'b0; wk = '0;
    chk("R9 device exit priority", sleep_o, 1'b0);

    // R10 ack during sleep does not restart delay
    do_reset();
    host_mode = 1'b1;
    pulse_ack();
    tick(100);
    pulse_ack();
    tick(RUS * CYC - 102);
    chk("R10 before delay end", resume_ok_o, 1'b0);
    tick(1);
    chk("R10 delay unchanged", resume_ok_o, 1'b1);
    chk("R10 still asleep", sleep_o, 1'b1);
    wk[8] = 1'b1; tick(1); wk = '0;
    chk("R8 cleared with sleep", resume_ok_o, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule